// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block holds the single exclusive-access reservation of one processor, the hardware half of a load-linked / store-conditional pair. A load-linked request records the cache line it touches and marks the reservation live. From then on the monitor watches two streams. One is the processor's own request port. The other is a snoop port carrying remote reads and writes from the coherence fabric. Any access that threatens the line drops the reservation.

A later store-conditional is judged against the reservation. The monitor returns a status code in which zero means success and any nonzero value means failure, and it enables the memory write only on success. Whether it passes or fails, every store-conditional consumes the reservation. An exception or context switch can also discard the reservation at once through a dedicated clear input. The monitor does not guarantee forward progress: a line under steady remote traffic can make store-conditionals fail indefinitely.

All results are registered. The status and the write enable for a request appear one clock after the request is presented.

Top module: `resv_monitor`

## Requirements
- R1: After reset, no reservation is held, and `sc_valid`, `sc_code`, `wr_en` and `wr_addr` are all zero.
- R2: `req_op` encodes 0 = plain load, 1 = plain store, 2 = load-linked, 3 = store-conditional. A load-linked marks the line `req_addr[ADDR_W-1:LINE_OFS_W]` as reserved and replaces any earlier reservation. Two addresses on the same line are equivalent.
- R3: A store-conditional that meets all of the following passes: a reservation is held, its line matches, and neither a matching snoop nor a clear falls in the same cycle. A pass gives `sc_code` = 0, `wr_en` = 1 and `wr_addr` = the request address one cycle later.
- R4: A store-conditional to a line other than the reserved one gives `sc_code` = 2 and no write.
- R5: A snoop (`snp_valid`, either a remote read or a remote write) to the reserved line drops the reservation. A snoop to any other line leaves it intact.
- R6: A snoop to the reserved line in the same cycle as a matching store-conditional wins. The store-conditional gives `sc_code` = 3 and no write.
- R7: `clear_i` drops the reservation in the cycle it is high, and it overrides a load-linked in that same cycle. A store-conditional presented together with `clear_i` gives `sc_code` = 1 and no write.
- R8: Every store-conditional, passing or failing, leaves no reservation behind.
- R9: A plain load never disturbs the reservation. A plain store is always written (`wr_en` = 1 with its address) and drops the reservation only when it hits the reserved line.
- R10: A store-conditional with no live reservation gives `sc_code` = 1 and no write.
- R11: `sc_valid` is high for exactly the cycle after a store-conditional, and `sc_code` is 0 whenever `sc_valid` is low. Plain loads and load-linked requests produce neither `sc_valid` nor `wr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | Local request kind (see R2) |
| req_addr | input | ADDR_W | Local request byte address |
| snp_valid | input | 1 | Remote read or write observed |
| snp_addr | input | ADDR_W | Remote access byte address |
| clear_i | input | 1 | Exception / context-switch reservation drop |
| sc_valid | output | 1 | Store-conditional result present |
| sc_code | output | 2 | Store-conditional status, 0 = success |
| wr_en | output | 1 | Store allowed to reach memory |
| wr_addr | output | ADDR_W | Address of the allowed store |

## Verification
Three events can land in the same cycle as a store-conditional: a remote snoop, a clear, or (through ordering) a load-linked followed by a snoop. The bench provokes the snoop collision by sweeping the snoop address over every byte address while a store-conditional targets the reserved line. Only same-line snoops must turn a pass into code 3. A clear is driven together with a store-conditional and with a load-linked, and the resulting status and any later store-conditional are compared with a bench model of the priority rules.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        SC_OK       = 2'd0,
        SC_NO_RESV  = 2'd1,
        SC_MISMATCH = 2'd2,
        SC_COLLIDE  = 2'd3
    } sc_code_e;

endpackage

// File: rtl/resv_line_cmp.sv
module resv_line_cmp #(
    parameter int ADDR_W     = 32,
    parameter int LINE_OFS_W = 6,
    parameter bit GATE_VALID = 1'b1
) (
    input  logic                         probe_valid,
    input  logic [ADDR_W-1:0]            probe_addr,
    input  logic                         held_valid,
    input  logic [ADDR_W-LINE_OFS_W-1:0] held_line,
    output logic                         hit
);
    localparam int LINE_W = ADDR_W - LINE_OFS_W;

    logic [LINE_W-1:0] probe_line;
    logic              same_line;

    assign probe_line = probe_addr[ADDR_W-1:LINE_OFS_W];
    assign same_line  = (probe_line == held_line);

    generate
        if (GATE_VALID) begin : g_gated
            assign hit = probe_valid && held_valid && same_line;
        end else begin : g_raw
            logic unused_held_valid;
            assign unused_held_valid = held_valid;
            assign hit = probe_valid && same_line;
        end
    endgenerate
endmodule

// File: rtl/resv_sc_judge.sv
module resv_sc_judge
    import resv_pkg::*;
(
    input  logic     is_cond,
    input  logic     held_valid,
    input  logic     line_match,
    input  logic     snoop_hit,
    input  logic     clear_now,
    output logic     pass,
    output sc_code_e code
);
    always_comb begin
        code = SC_OK;
        if (!is_cond) begin
            code = SC_OK;
        end else if (!held_valid || clear_now) begin
            code = SC_NO_RESV;
        end else if (!line_match) begin
            code = SC_MISMATCH;
        end else if (snoop_hit) begin
            code = SC_COLLIDE;
        end else begin
            code = SC_OK;
        end
        pass = is_cond && (code == SC_OK);
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_OFS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              clear_i,
    output logic              sc_valid,
    output logic [1:0]        sc_code,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam int LINE_W = ADDR_W - LINE_OFS_W;

    typedef struct packed {
        logic              resv_valid;
        logic [LINE_W-1:0] resv_line;
        logic              sc_valid;
        sc_code_e          sc_code;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic              resv_valid;
    logic [LINE_W-1:0] resv_line;
    assign resv_valid = st_q.resv_valid;
    assign resv_line  = st_q.resv_line;

    req_op_e op;
    assign op = req_op_e'(req_op);

    logic is_load, is_store, is_link, is_cond;
    assign is_load  = req_valid && (op == OP_LOAD);
    assign is_store = req_valid && (op == OP_STORE);
    assign is_link  = req_valid && (op == OP_LINK);
    assign is_cond  = req_valid && (op == OP_COND);

    logic unused_load;
    assign unused_load = is_load;

    logic req_line_eq;
    logic snp_hit;

    resv_line_cmp #(
        .ADDR_W(ADDR_W), .LINE_OFS_W(LINE_OFS_W), .GATE_VALID(1'b0)
    ) u_req_cmp (
        .probe_valid (req_valid),
        .probe_addr  (req_addr),
        .held_valid  (st_q.resv_valid),
        .held_line   (st_q.resv_line),
        .hit         (req_line_eq)
    );

    resv_line_cmp #(
        .ADDR_W(ADDR_W), .LINE_OFS_W(LINE_OFS_W), .GATE_VALID(1'b1)
    ) u_snp_cmp (
        .probe_valid (snp_valid),
        .probe_addr  (snp_addr),
        .held_valid  (st_q.resv_valid),
        .held_line   (st_q.resv_line),
        .hit         (snp_hit)
    );

    logic     sc_pass;
    sc_code_e sc_result;

    resv_sc_judge u_judge (
        .is_cond    (is_cond),
        .held_valid (st_q.resv_valid),
        .line_match (req_line_eq),
        .snoop_hit  (snp_hit),
        .clear_now  (clear_i),
        .pass       (sc_pass),
        .code       (sc_result)
    );

    always_comb begin
        st_d = st_q;

        // reservation tracking, later statements take priority
        if (snp_hit) begin
            st_d.resv_valid = 1'b0;
        end
        if (is_store && req_line_eq && st_q.resv_valid) begin
            st_d.resv_valid = 1'b0;
        end
        if (is_cond) begin
            st_d.resv_valid = 1'b0;
        end
        if (is_link) begin
            st_d.resv_valid = 1'b1;
            st_d.resv_line  = req_addr[ADDR_W-1:LINE_OFS_W];
        end
        if (clear_i) begin
            st_d.resv_valid = 1'b0;
        end

        // result and write path
        st_d.sc_valid = is_cond;
        st_d.sc_code  = is_cond ? sc_result : SC_OK;
        st_d.wr_en    = is_store || sc_pass;
        st_d.wr_addr  = (is_store || sc_pass) ? req_addr : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sc_valid = st_q.sc_valid;
    assign sc_code  = st_q.sc_code;
    assign wr_en    = st_q.wr_en;
    assign wr_addr  = st_q.wr_addr;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_OFS_W = 6
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic [1:0]                   req_op,
    input logic [ADDR_W-1:0]            req_addr,
    input logic                         snp_valid,
    input logic [ADDR_W-1:0]            snp_addr,
    input logic                         clear_i,
    input logic                         resv_valid,
    input logic [ADDR_W-LINE_OFS_W-1:0] resv_line,
    input logic                         sc_valid,
    input logic [1:0]                   sc_code,
    input logic                         wr_en
);
    logic cond_req;
    assign cond_req = req_valid && (req_op == 2'd3);

    p_pass_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && sc_code == 2'd0) |-> wr_en);

    p_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_req && !clear_i && resv_valid &&
         req_addr[ADDR_W-1:LINE_OFS_W] != resv_line) |=> (sc_code == 2'd2 && !wr_en));

    p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_req && !clear_i && resv_valid && snp_valid &&
         req_addr[ADDR_W-1:LINE_OFS_W] == resv_line &&
         snp_addr[ADDR_W-1:LINE_OFS_W] == resv_line) |=> (sc_code == 2'd3 && !wr_en));

    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !resv_valid);

    p_cond_consumes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cond_req |=> !resv_valid);

    p_snoop_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && resv_valid && snp_addr[ADDR_W-1:LINE_OFS_W] == resv_line &&
         !(req_valid && req_op == 2'd2)) |=> !resv_valid);

    p_result_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cond_req |=> sc_valid);

    p_code_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |-> sc_code == 2'd0);
endmodule

bind resv_monitor resv_monitor_chk #(
    .ADDR_W(ADDR_W), .LINE_OFS_W(LINE_OFS_W)
) u_chk (.*);

// File: tb/resv_monitor_tb.sv
`timescale 1ns/1ps
module resv_monitor_tb;
    localparam int AW  = 8;
    localparam int OFS = 2;
    localparam int LW  = AW - OFS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          clear_i = 1'b0;
    logic          sc_valid;
    logic [1:0]    sc_code;
    logic          wr_en;
    logic [AW-1:0] wr_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model of the reservation
    logic          m_valid = 1'b0;
    logic [LW-1:0] m_line  = '0;

    always #2.5 clk = ~clk;

    resv_monitor #(.ADDR_W(AW), .LINE_OFS_W(OFS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .clear_i(clear_i), .sc_valid(sc_valid), .sc_code(sc_code),
        .wr_en(wr_en), .wr_addr(wr_addr)
    );

    task automatic check(input string tag, input logic [AW+3:0] act, input logic [AW+3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compute expectation, sample after edge
    task automatic step(input string tag, input logic rv, input logic [1:0] op,
                        input logic [AW-1:0] a, input logic sv,
                        input logic [AW-1:0] sa, input logic clr);
        logic          e_scv, e_wr;
        logic [1:0]    e_code;
        logic [AW-1:0] e_wa;
        logic          same, shit;
        @(negedge clk);
        req_valid = rv; req_op = op; req_addr = a;
        snp_valid = sv; snp_addr = sa; clear_i = clr;
        same = (a[AW-1:OFS] == m_line);
        shit = sv && m_valid && (sa[AW-1:OFS] == m_line);
        e_scv = rv && op == 2'd3;
        e_code = 2'd0;
        if (e_scv) begin
            if (!m_valid || clr)      e_code = 2'd1;
            else if (!same)           e_code = 2'd2;
            else if (shit)            e_code = 2'd3;
            else                      e_code = 2'd0;
        end
        e_wr = rv && (op == 2'd1 || (e_scv && e_code == 2'd0));
        e_wa = e_wr ? a : '0;
        if (shit) m_valid = 1'b0;
        if (rv && op == 2'd1 && same) m_valid = 1'b0;
        if (e_scv) m_valid = 1'b0;
        if (rv && op == 2'd2) begin m_valid = 1'b1; m_line = a[AW-1:OFS]; end
        if (clr) m_valid = 1'b0;
        @(posedge clk);
        #1;
        check(tag, {sc_valid, sc_code, wr_en, wr_addr}, {e_scv, e_code, e_wr, e_wa});
    endtask

    task automatic idle();
        step("idle R11", 1'b0, 2'd0, '0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", {sc_valid, sc_code, wr_en, wr_addr}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1/R10: no reservation after reset
        step("R10 sc without resv", 1'b1, 2'd3, 8'h10, 1'b0, '0, 1'b0);

        // R2/R3/R4: every link line against every SC address
        for (int l = 0; l < (1 << LW); l++) begin
            for (int b = 0; b < (1 << AW); b++) begin
                step("R2 link", 1'b1, 2'd2, AW'(l * 4 + (b % 4)), 1'b0, '0, 1'b0);
                step("R3 R4 sc sweep", 1'b1, 2'd3, AW'(b), 1'b0, '0, 1'b0);
            end
        end

        // R5: snoop at every address between link and SC
        for (int l = 0; l < (1 << LW); l += 9) begin
            for (int s = 0; s < (1 << AW); s++) begin
                step("R2 link", 1'b1, 2'd2, AW'(l * 4), 1'b0, '0, 1'b0);
                step("R5 snoop", 1'b0, 2'd0, '0, 1'b1, AW'(s), 1'b0);
                step("R5 sc after snoop", 1'b1, 2'd3, AW'(l * 4 + 3), 1'b0, '0, 1'b0);
            end
        end

        // R6: snoop at every address in the SC cycle
        for (int s = 0; s < (1 << AW); s++) begin
            step("R2 link", 1'b1, 2'd2, 8'h84, 1'b0, '0, 1'b0);
            step("R6 collide", 1'b1, 2'd3, 8'h86, 1'b1, AW'(s), 1'b0);
        end

        // R7: clear alone, with SC, with link
        step("R2 link", 1'b1, 2'd2, 8'h40, 1'b0, '0, 1'b0);
        step("R7 clear", 1'b0, 2'd0, '0, 1'b0, '0, 1'b1);
        step("R7 sc after clear", 1'b1, 2'd3, 8'h40, 1'b0, '0, 1'b0);
        step("R2 link", 1'b1, 2'd2, 8'h40, 1'b0, '0, 1'b0);
        step("R7 sc with clear", 1'b1, 2'd3, 8'h40, 1'b0, '0, 1'b1);
        step("R7 link with clear", 1'b1, 2'd2, 8'h40, 1'b0, '0, 1'b1);
        step("R7 sc after link+clear", 1'b1, 2'd3, 8'h40, 1'b0, '0, 1'b0);

        // R8: second SC after pass and after fail
        step("R2 link", 1'b1, 2'd2, 8'h20, 1'b0, '0, 1'b0);
        step("R8 sc pass", 1'b1, 2'd3, 8'h20, 1'b0, '0, 1'b0);
        step("R8 sc again", 1'b1, 2'd3, 8'h20, 1'b0, '0, 1'b0);
        step("R2 link", 1'b1, 2'd2, 8'h20, 1'b0, '0, 1'b0);
        step("R8 sc mismatch", 1'b1, 2'd3, 8'h30, 1'b0, '0, 1'b0);
        step("R8 sc after fail", 1'b1, 2'd3, 8'h20, 1'b0, '0, 1'b0);

        // R9: loads and stores between link and SC
        for (int a = 0; a < (1 << AW); a += 5) begin
            step("R2 link", 1'b1, 2'd2, 8'h64, 1'b0, '0, 1'b0);
            step("R9 load", 1'b1, 2'd0, AW'(a), 1'b0, '0, 1'b0);
            step("R9 store", 1'b1, 2'd1, AW'(a ^ 8'h55), 1'b0, '0, 1'b0);
            step("R9 sc", 1'b1, 2'd3, 8'h65, 1'b0, '0, 1'b0);
            idle();
        end

        // R2: replacement by a second link; snoop concurrent with link
        step("R2 link A", 1'b1, 2'd2, 8'h08, 1'b0, '0, 1'b0);
        step("R2 link B", 1'b1, 2'd2, 8'hF0, 1'b0, '0, 1'b0);
        step("R2 sc old line", 1'b1, 2'd3, 8'h08, 1'b0, '0, 1'b0);
        step("R2 link B", 1'b1, 2'd2, 8'hF0, 1'b1, 8'hF1, 1'b0);
        step("R2 sc new line", 1'b1, 2'd3, 8'hF3, 1'b0, '0, 1'b0);
        idle();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule